// File: doc/BRIEF.md
# Guaranteed-Hit Filter Instruction Cache

This block is a very small direct-mapped instruction store placed ahead of a larger L1 instruction cache. It does not compare tags on each fetch. Instead, one cycle before a fetch it decides whether that fetch is certain to find its instruction locally. A certain fetch reads the local copy with no tag check and leaves the L1 idle. Any other fetch reads the L1 in the same cycle, so no fetch pays a miss penalty.

The proof of residency comes from link bits written while code runs. A per-line sequential link says that the following modulo line holds the following memory line. A per-instruction target link says that the taken-transfer target of that instruction is resident. A fetch that is not certain compares the stored line identifier with the PC. If they match, the fetch is a false miss and nothing is replaced. If they differ, the line is refilled from the L1 word vector and every link that could now be wrong is cleared. Each line has a source vector that records which lines may hold target links into it.

The fetch PC is a word address. Bits [1:0] select the word, bits [5:2] select the line and bits [11:6] are the line identifier. The front end supplies a taken indication with every fetch. The L1 returns the whole line for the current PC combinationally.

Top module: `hitguard_icache`

## Requirements
- R1: After reset all valid and link state is clear. The first fetch after reset is served by the L1 (`l1_rd_o`=1, `hit_o`=0).
- R2: Every delivered instruction on `instr_o` equals the memory word at `fetch_pc_i`, whether it comes from the local copy or from `l1_line_i`. Word w of `l1_line_i` sits at bits [32w+31:32w].
- R3: A fetch with `fetch_taken_i`=0 at word offset 0, 1 or 2 makes the next fetch a guaranteed hit (`hit_o`=1, `l1_rd_o`=0).
- R4: A non-taken fetch of word offset 3 in line i makes the next fetch a guaranteed hit only when the sequential link of line i is set. That link is set when a non-guaranteed fetch of line i+1 (mod 16) directly follows a non-taken fetch of word 3 of line i.
- R5: A taken fetch makes the next fetch a guaranteed hit only when that instruction's target link is set. A non-guaranteed fetch directly after a taken fetch sets the target link of the taken instruction.
- R6: A non-guaranteed fetch whose line is valid with a matching identifier is a false miss: `l1_rd_o`=1, `fill_o`=0, and no line is replaced.
- R7: A non-guaranteed fetch whose line is invalid or has another identifier writes that line from `l1_line_i` with the new identifier (`fill_o`=1).
- R8: Replacing a line clears the target links of every line recorded in its source vector. A taken transfer from those lines then goes to the L1 again.
- R9: Replacing line i clears the sequential links of line i and line i-1 (mod 16) and the target links of line i's own words.
- R10: A cycle with `fetch_valid_i`=0 leaves the pending decision and the last-fetch pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_valid_i | input | 1 | A fetch happens this cycle |
| fetch_pc_i | input | 12 | Word address of the fetch |
| fetch_taken_i | input | 1 | The fetched instruction is predicted to transfer control |
| l1_line_i | input | 128 | L1 line holding `fetch_pc_i`, four 32-bit words |
| instr_o | output | 32 | Delivered instruction |
| hit_o | output | 1 | Fetch served by the local copy with no tag check |
| l1_rd_o | output | 1 | Fetch served by the L1 |
| fill_o | output | 1 | Fetch replaces its local line |

## Verification
The stimulus first walks straight-line code across a line boundary, so the sequential link is learned and then used. It then runs a loop whose back edge learns and uses a target link, which separates a correct decision from one that forces a false miss. Next it branches to a conflicting line that shares an index, so that a stale target link and a stale sequential link would each turn a required L1 fetch into a wrong guaranteed hit. Idle cycles and a mid-run reset check that the pending decision holds and that reset returns every fetch to the L1.

// File: rtl/hitguard_pkg.sv
package hitguard_pkg;
  typedef enum logic {
    SRC_L1     = 1'b0,
    SRC_FILTER = 1'b1
  } fetch_src_e;
endpackage

// File: rtl/hitguard_store.sv
module hitguard_store #(
  parameter int unsigned LINES  = 16,
  parameter int unsigned WORDS  = 4,
  parameter int unsigned ID_W   = 6,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(LINES),
  localparam int unsigned OFF_W = $clog2(WORDS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic [OFF_W-1:0]              off_i,
  input  logic [ID_W-1:0]               tag_i,
  input  logic                          we_i,
  input  logic [WORDS-1:0][DATA_W-1:0]  line_i,
  output logic [DATA_W-1:0]             word_o,
  output logic                          resident_o
);
  logic [WORDS-1:0][DATA_W-1:0] data_q [LINES];
  logic [ID_W-1:0]              id_q   [LINES];
  logic [LINES-1:0]             vld_q, vld_n;

  always_comb begin
    vld_n = vld_q;
    if (we_i) vld_n[idx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else if (we_i) vld_q <= vld_n;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      data_q[idx_i] <= line_i;
      id_q[idx_i]   <= tag_i;
    end
  end

  assign word_o     = data_q[idx_i][off_i];
  assign resident_o = vld_q[idx_i] && (id_q[idx_i] == tag_i);

  // R7: a written line is valid and carries the new identifier next cycle
  p_fill_lands_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (vld_q[$past(idx_i)] && (id_q[$past(idx_i)] == $past(tag_i))));
endmodule

// File: rtl/hitguard_links.sv
module hitguard_links #(
  parameter int unsigned LINES = 16,
  parameter int unsigned WORDS = 4,
  localparam int unsigned IDX_W = $clog2(LINES),
  localparam int unsigned OFF_W = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             refill_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             link_seq_i,
  input  logic             link_tgt_i,
  input  logic [IDX_W-1:0] last_line_i,
  input  logic [OFF_W-1:0] last_off_i,
  input  logic [OFF_W-1:0] cur_off_i,
  output logic             nt_cur_o,
  output logic             ns_cur_o
);
  logic [LINES-1:0] ns_q, ns_n;
  logic [WORDS-1:0] nt_q [LINES];
  logic [WORDS-1:0] nt_n [LINES];
  logic [LINES-1:0] src_q [LINES];
  logic [LINES-1:0] src_n [LINES];
  logic             upd;

  assign upd = refill_i || link_seq_i || link_tgt_i;

  always_comb begin
    ns_n  = ns_q;
    nt_n  = nt_q;
    src_n = src_q;
    if (refill_i) begin
      ns_n[idx_i]                 = 1'b0;
      ns_n[IDX_W'(idx_i - 1'b1)]  = 1'b0;
      nt_n[idx_i]                 = '0;
      for (int l = 0; l < LINES; l++) begin
        if (src_q[idx_i][l]) nt_n[l] = '0;
      end
      src_n[idx_i] = '0;
    end
    if (link_seq_i) ns_n[last_line_i] = 1'b1;
    if (link_tgt_i) begin
      nt_n[last_line_i][last_off_i] = 1'b1;
      src_n[idx_i][last_line_i]     = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ns_q <= '0;
      for (int l = 0; l < LINES; l++) begin
        nt_q[l]  <= '0;
        src_q[l] <= '0;
      end
    end else if (upd) begin
      ns_q  <= ns_n;
      nt_q  <= nt_n;
      src_q <= src_n;
    end
  end

  assign nt_cur_o = nt_n[idx_i][cur_off_i];
  assign ns_cur_o = ns_n[idx_i];

  // R9: a replaced line keeps no sequential or target link of its own
  p_own_links_cleared_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_i |=> (!ns_q[$past(idx_i)] && (nt_q[$past(idx_i)] == '0)));

  // R5, R8: a learned target link is recorded in the target line's source vector
  p_tgt_logged_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_tgt_i |=> (nt_q[$past(last_line_i)][$past(last_off_i)] &&
                    src_q[$past(idx_i)][$past(last_line_i)]));
endmodule

// File: rtl/hitguard_icache.sv
module hitguard_icache
  import hitguard_pkg::*;
#(
  parameter int unsigned LINES  = 16,
  parameter int unsigned WORDS  = 4,
  parameter int unsigned ID_W   = 6,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(LINES),
  localparam int unsigned OFF_W = $clog2(WORDS),
  localparam int unsigned PC_W  = ID_W + IDX_W + OFF_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fetch_valid_i,
  input  logic [PC_W-1:0]         fetch_pc_i,
  input  logic                    fetch_taken_i,
  input  logic [WORDS*DATA_W-1:0] l1_line_i,
  output logic [DATA_W-1:0]       instr_o,
  output logic                    hit_o,
  output logic                    l1_rd_o,
  output logic                    fill_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [OFF_W-1:0] off;
  logic [IDX_W-1:0] idx;
  logic [ID_W-1:0]  tag;
  assign off = fetch_pc_i[OFF_W-1:0];
  assign idx = fetch_pc_i[OFF_W +: IDX_W];
  assign tag = fetch_pc_i[PC_W-1 -: ID_W];

  fetch_src_e       src_q, src_n;
  logic             have_last_q, have_last_n;
  logic [IDX_W-1:0] last_line_q, last_line_n;
  logic [OFF_W-1:0] last_off_q, last_off_n;
  logic             last_tk_q, last_tk_n;

  logic guar, nonguar, resident, refill, link_ok, link_tgt, link_seq;
  logic nt_cur, ns_cur;
  logic [DATA_W-1:0] local_word;

  assign guar     = fetch_valid_i && (src_q == SRC_FILTER);
  assign nonguar  = fetch_valid_i && (src_q == SRC_L1);
  assign refill   = nonguar && !resident;
  assign link_ok  = have_last_q && !(refill && (last_line_q == idx));
  assign link_tgt = nonguar && link_ok && last_tk_q;
  assign link_seq = nonguar && link_ok && !last_tk_q &&
                    (last_off_q == OFF_W'(WORDS-1)) &&
                    (idx == IDX_W'(last_line_q + 1'b1));

  hitguard_store #(.LINES(LINES), .WORDS(WORDS), .ID_W(ID_W), .DATA_W(DATA_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .idx_i      (idx),
    .off_i      (off),
    .tag_i      (tag),
    .we_i       (refill),
    .line_i     (l1_line_i),
    .word_o     (local_word),
    .resident_o (resident)
  );

  hitguard_links #(.LINES(LINES), .WORDS(WORDS)) u_links (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .refill_i    (refill),
    .idx_i       (idx),
    .link_seq_i  (link_seq),
    .link_tgt_i  (link_tgt),
    .last_line_i (last_line_q),
    .last_off_i  (last_off_q),
    .cur_off_i   (off),
    .nt_cur_o    (nt_cur),
    .ns_cur_o    (ns_cur)
  );

  always_comb begin
    have_last_n = 1'b1;
    last_line_n = idx;
    last_off_n  = off;
    last_tk_n   = fetch_taken_i;
    if (fetch_taken_i)                  src_n = nt_cur ? SRC_FILTER : SRC_L1;
    else if (off != OFF_W'(WORDS-1))    src_n = SRC_FILTER;
    else                                src_n = ns_cur ? SRC_FILTER : SRC_L1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      src_q       <= SRC_L1;
      have_last_q <= 1'b0;
      last_line_q <= '0;
      last_off_q  <= '0;
      last_tk_q   <= 1'b0;
    end else if (fetch_valid_i) begin
      src_q       <= src_n;
      have_last_q <= have_last_n;
      last_line_q <= last_line_n;
      last_off_q  <= last_off_n;
      last_tk_q   <= last_tk_n;
    end
  end

  assign instr_o = guar ? local_word : l1_line_i[off*DATA_W +: DATA_W];
  assign hit_o   = guar;
  assign l1_rd_o = nonguar;
  assign fill_o  = refill;

  // R2: a guaranteed hit always finds its line valid with the right identifier
  p_hit_resident_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    guar |-> resident);

  // R1: until the first fetch after reset, the pending decision is the L1
  p_first_fetch_l1_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    !have_last_q |-> (src_q == SRC_L1));

  // R10: idle cycles keep the pending decision
  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !fetch_valid_i |=> $stable(src_q));
endmodule

// File: tb/tb_hitguard_icache.sv
module tb_hitguard_icache;
  logic         clk = 1'b0;
  logic         rst_ni;
  logic         fetch_valid;
  logic [11:0]  fetch_pc;
  logic         fetch_taken;
  logic [127:0] l1_line;
  logic [31:0]  instr;
  logic         hit, l1_rd, fill;

  int n_checks = 0;
  int n_bad    = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  hitguard_icache dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .fetch_valid_i (fetch_valid),
    .fetch_pc_i    (fetch_pc),
    .fetch_taken_i (fetch_taken),
    .l1_line_i     (l1_line),
    .instr_o       (instr),
    .hit_o         (hit),
    .l1_rd_o       (l1_rd),
    .fill_o        (fill)
  );

  function automatic logic [31:0] mem_word(logic [11:0] pc);
    return {8'hC3, pc, ~pc};
  endfunction

  always_comb begin
    for (int w = 0; w < 4; w++)
      l1_line[w*32 +: 32] = mem_word({fetch_pc[11:2], 2'(w)});
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // fields: pc[14:3], taken[2], expected hit[1], expected fill[0]
  localparam int NV = 26;
  localparam logic [14:0] VEC [NV] = '{
    {12'h000, 1'b0, 1'b0, 1'b1},  // R1 R7 cold miss
    {12'h001, 1'b0, 1'b1, 1'b0},  // R3
    {12'h002, 1'b0, 1'b1, 1'b0},  // R3
    {12'h003, 1'b0, 1'b1, 1'b0},  // R3
    {12'h004, 1'b0, 1'b0, 1'b1},  // R4 no link yet, R7 fill, learns link
    {12'h005, 1'b1, 1'b1, 1'b0},  // R3
    {12'h000, 1'b0, 1'b0, 1'b0},  // R5 no target link, R6 false miss
    {12'h001, 1'b0, 1'b1, 1'b0},
    {12'h002, 1'b0, 1'b1, 1'b0},
    {12'h003, 1'b0, 1'b1, 1'b0},
    {12'h004, 1'b0, 1'b1, 1'b0},  // R4 sequential link used
    {12'h005, 1'b1, 1'b1, 1'b0},
    {12'h000, 1'b1, 1'b1, 1'b0},  // R5 target link used
    {12'h040, 1'b0, 1'b0, 1'b1},  // R7 conflict replaces line 0
    {12'h041, 1'b1, 1'b1, 1'b0},  // R2 new contents
    {12'h005, 1'b1, 1'b0, 1'b0},  // R6 false miss
    {12'h040, 1'b0, 1'b0, 1'b0},  // R8 link of 005 was cleared
    {12'h041, 1'b0, 1'b1, 1'b0},
    {12'h042, 1'b0, 1'b1, 1'b0},
    {12'h043, 1'b0, 1'b1, 1'b0},
    {12'h044, 1'b0, 1'b0, 1'b1},  // R9 own sequential link cleared, R7
    {12'h045, 1'b0, 1'b1, 1'b0},
    {12'h046, 1'b0, 1'b1, 1'b0},
    {12'h047, 1'b1, 1'b1, 1'b0},
    {12'h041, 1'b1, 1'b0, 1'b0},  // R5 unlearned, R6
    {12'h045, 1'b0, 1'b0, 1'b0}   // R8 link of 041 cleared by line 1 refill
  };

  task automatic apply(logic [11:0] pc, logic tk, logic e_hit, logic e_fill, string tagm);
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_pc    = pc;
    fetch_taken = tk;
    #2;
    chk($sformatf("R2 instr pc=%h", pc), instr, mem_word(pc));
    chk($sformatf("%s hit pc=%h", tagm, pc), 32'(hit), 32'(e_hit));
    chk($sformatf("%s l1_rd pc=%h", tagm, pc), 32'(l1_rd), 32'(!e_hit));
    chk($sformatf("R6 R7 fill pc=%h", pc), 32'(fill), 32'(e_fill));
  endtask

  task automatic do_reset();
    @(negedge clk);
    fetch_valid = 1'b0;
    rst_ni      = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_ni      = 1'b0;
    fetch_valid = 1'b0;
    fetch_pc    = '0;
    fetch_taken = 1'b0;
    do_reset();
    #2;
    chk("R1 idle hit after reset", 32'(hit), 32'd0);
    chk("R1 idle fill after reset", 32'(fill), 32'd0);

    for (int i = 0; i < NV; i++)
      apply(VEC[i][14:3], VEC[i][2], VEC[i][1], VEC[i][0], "R3 R4 R5 R8 R9");

    // R10: idle cycles keep the pending guaranteed decision
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      fetch_valid = 1'b0;
      #2;
      chk("R10 idle l1_rd", 32'(l1_rd), 32'd0);
      chk("R10 idle hit", 32'(hit), 32'd0);
      chk("R10 idle fill", 32'(fill), 32'd0);
    end
    apply(12'h046, 1'b0, 1'b1, 1'b0, "R10");

    // R1: reset clears residency and links
    do_reset();
    apply(12'h046, 1'b0, 1'b0, 1'b1, "R1");
    apply(12'h047, 1'b0, 1'b1, 1'b0, "R3");

    @(negedge clk);
    fetch_valid = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
      $finish;
    end
  end
endmodule